// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block holds a three-register time-of-day alarm (minutes, hours, day of week) and compares it with the running clock. The time counters are not part of the block. They arrive as BCD inputs together with a one-cycle evaluate strobe, which the clock logic raises once per second while the hundredths count sits at 99. Each alarm register uses bit 7 as a "don't care" mask. Setting the masks cumulatively turns the alarm from a single weekly match into a daily, hourly or per-minute alarm.

A match sets a sticky alarm flag and an active-high interrupt, and both stay set until the host touches the alarm registers. The registers sit on a small synchronous host bus and are read and written in the same BCD layout as the time registers. Any read or write of one of the three alarm slots acknowledges a pending alarm. A read returns data on the cycle after the request.

Top module: `tod_alarm`

## Requirements
- R1: After a synchronous active-high reset, `alarm_flag`, `alarm_irq` and `bus_rdata` are 0, and all three alarm registers read 0.
- R2: Host slot 0 is the minute alarm, slot 1 the hour alarm and slot 2 the day alarm. A write with `bus_sel`=1 and `bus_we`=1 stores `bus_wdata`. A read with `bus_sel`=1 and `bus_we`=0 puts the slot's value on `bus_rdata` one cycle later. Slot 3 always reads 0, and `bus_rdata` is 0 on any cycle that follows no read.
- R3: The day alarm keeps only bit 7 and bits 2:0, so bits 6:3 of slot 2 always read zero.
- R4: With no mask bit set, an evaluation (`tick_chk`=1) raises the alarm only when `cur_min[6:0]`, `cur_hour[6:0]` and `cur_day[2:0]` all equal the corresponding stored bits.
- R5: With only the day mask (slot 2 bit 7) set, the day is ignored and the alarm fires on any evaluation where hour and minute match.
- R6: With the day and hour masks (slot 2 bit 7, slot 1 bit 7) set, the alarm fires on any evaluation where the minute matches.
- R7: When the minute mask (slot 0 bit 7) is set, the minute is ignored and an evaluation fires only while `cur_sec` is 8'h59, the second about to roll to 00. With all three masks set this gives one alarm per minute. In general, a masked field is left out of the comparison.
- R8: Without `tick_chk`, matching time values never raise the alarm.
- R9: `alarm_flag` and `alarm_irq` rise together on the cycle after a firing evaluation. They hold until a read or write of slot 0, 1 or 2 clears both on the following cycle. An access to slot 3 does not clear them.
- R10: If a firing evaluation and an alarm-slot access fall in the same cycle, the alarm is set, and the match uses the register contents from before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Alarm slot: 0 minute, 1 hour, 2 day, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_chk | input | 1 | Evaluate strobe from the time counters |
| cur_sec | input | 8 | Running seconds, BCD |
| cur_min | input | 8 | Running minutes, BCD |
| cur_hour | input | 8 | Running hours, BCD with format bits |
| cur_day | input | 8 | Running day of week |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt, active high |

## Verification
A host access to the alarm registers and an evaluation strobe can arrive in the same cycle. The access asks to clear the alarm while the evaluation may ask to set it. A directed step raises `tick_chk` on a matching time while reading and writing an alarm slot. The check expects the flag and interrupt set afterwards, with the match judged against the values stored before the write. The random phase issues accesses and evaluations independently every cycle. There the bench model, which gives setting priority over clearing, judges every collision it produces.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  parameter int unsigned DW    = 8;
  parameter int unsigned DAY_W = 3;

  typedef enum logic [1:0] {
    SLOT_MIN  = 2'd0,
    SLOT_HOUR = 2'd1,
    SLOT_DAY  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  typedef struct packed {
    logic [DW-1:0] min_r;
    logic [DW-1:0] hour_r;
    logic [DW-1:0] day_r;
  } alarm_cfg_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import tod_alarm_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned DWD = DAY_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         acc,
  input  logic         we,
  input  slot_e        slot,
  input  logic [W-1:0] wdata,
  output alarm_cfg_t   cfg,
  output logic [W-1:0] rdata,
  output logic         clr
);
  localparam logic [W-1:0] DAY_KEEP = {1'b1, {(W-1-DWD){1'b0}}, {DWD{1'b1}}};

  assign clr = acc && (slot != SLOT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (acc && we) begin
        case (slot)
          SLOT_MIN:  cfg.min_r  <= wdata;
          SLOT_HOUR: cfg.hour_r <= wdata;
          SLOT_DAY:  cfg.day_r  <= wdata & DAY_KEEP;
          default: ;
        endcase
      end else if (acc) begin
        case (slot)
          SLOT_MIN:  rdata <= cfg.min_r;
          SLOT_HOUR: rdata <= cfg.hour_r;
          SLOT_DAY:  rdata <= cfg.day_r;
          default:   rdata <= '0;
        endcase
      end
    end
  end

  p_day_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && !we && slot == SLOT_DAY) |=> ((rdata & ~DAY_KEEP) == '0));
  p_unused_slot_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && !we && slot == SLOT_NONE) |=> (rdata == '0));
  p_idle_rdata_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !(acc && !we) |=> (rdata == '0));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int unsigned W   = DW,
  parameter int unsigned DWD = DAY_W
) (
  input  logic         clk,
  input  logic         rst,
  input  alarm_cfg_t   cfg,
  input  logic         chk,
  input  logic [W-1:0] sec,
  input  logic [W-1:0] min,
  input  logic [W-1:0] hour,
  input  logic [W-1:0] day,
  output logic         hit
);
  localparam logic [W-1:0] SEC_LAST = W'('h59);
  localparam int unsigned NF = 3;

  logic [NF-1:0] field_ok;
  logic [NF-1:0] field_mask;
  logic [W-2:0]  cur_f [NF];
  logic [W-2:0]  ref_f [NF];

  assign cur_f[0] = min[W-2:0];
  assign ref_f[0] = cfg.min_r[W-2:0];
  assign cur_f[1] = hour[W-2:0];
  assign ref_f[1] = cfg.hour_r[W-2:0];
  assign cur_f[2] = (W-1)'(day[DWD-1:0]);
  assign ref_f[2] = (W-1)'(cfg.day_r[DWD-1:0]);
  assign field_mask = {cfg.day_r[W-1], cfg.hour_r[W-1], cfg.min_r[W-1]};

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign field_ok[i] = field_mask[i] || (cur_f[i] == ref_f[i]);
  end

  assign hit = chk && (&field_ok) && (!field_mask[0] || sec == SEC_LAST);

  p_minute_mask_rollover_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && cfg.min_r[W-1]) |-> (sec == SEC_LAST));
  p_no_strobe_no_hit_r8: assert property (@(posedge clk) disable iff (rst)
    !chk |-> !hit);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic flag,
  output logic irq
);
  logic nxt;

  always_comb begin
    nxt = flag;
    if (clr) nxt = 1'b0;
    if (hit) nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= nxt;
      irq  <= nxt;
    end
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    hit |=> (flag && irq));
  p_clear_on_access_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> (!flag && !irq));
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hit) |=> $stable(flag));
  p_irq_follows_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq == flag);
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_chk,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_day,
  output logic          alarm_flag,
  output logic          alarm_irq
);
  alarm_cfg_t cfg;
  logic       clr;
  logic       hit;

  alarm_regs #(.W(DW), .DWD(DAY_W)) u_regs (
    .clk(clk), .rst(rst), .acc(bus_sel), .we(bus_we),
    .slot(slot_e'(bus_addr)), .wdata(bus_wdata),
    .cfg(cfg), .rdata(bus_rdata), .clr(clr)
  );

  alarm_match #(.W(DW), .DWD(DAY_W)) u_match (
    .clk(clk), .rst(rst), .cfg(cfg), .chk(tick_chk),
    .sec(cur_sec), .min(cur_min), .hour(cur_hour), .day(cur_day),
    .hit(hit)
  );

  alarm_flag u_flag (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr),
    .flag(alarm_flag), .irq(alarm_irq)
  );
endmodule

// File: tb/tb_tod_alarm.sv
module tb_tod_alarm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0, tick_chk = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0;
  logic [7:0] bus_rdata;
  logic       alarm_flag, alarm_irq;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  logic [7:0] m_min = 0, m_hour = 0, m_day = 0, m_rd = 0;
  logic       m_flag = 0;

  tod_alarm dut (.*);

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  function automatic logic exp_hit(logic [7:0] mi, logic [7:0] hr, logic [7:0] dy, logic [7:0] se);
    logic ok;
    ok = (m_min[7]  || mi[6:0] == m_min[6:0]) &&
         (m_hour[7] || hr[6:0] == m_hour[6:0]) &&
         (m_day[7]  || dy[2:0] == m_day[2:0]) &&
         (!m_min[7] || se == 8'h59);
    return ok;
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_min;
      2'd1: return m_hour;
      2'd2: return m_day;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic s, logic w, logic [1:0] a, logic [7:0] d,
                      logic c, logic [7:0] mi, logic [7:0] hr, logic [7:0] dy, logic [7:0] se);
    logic h;
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    tick_chk = c; cur_min = mi; cur_hour = hr; cur_day = dy; cur_sec = se;
    h = c && exp_hit(mi, hr, dy, se);
    m_rd = (s && !w) ? exp_read(a) : 8'h00;
    if (s && a != 2'd3) m_flag = 1'b0;
    if (h) m_flag = 1'b1;
    if (s && w) begin
      case (a)
        2'd0: m_min = d;
        2'd1: m_hour = d;
        2'd2: m_day = d & 8'h87;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    chk8(tag, "flag", {7'd0, alarm_flag}, {7'd0, m_flag});
    chk8(tag, "irq", {7'd0, alarm_irq}, {7'd0, m_flag});
    chk8(tag, "rdata", bus_rdata, m_rd);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(string tag, logic [1:0] a, logic [7:0] d);
    step(tag, 1, 1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(string tag, logic [1:0] a);
    step(tag, 1, 0, a, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ev(string tag, logic [7:0] mi, logic [7:0] hr, logic [7:0] dy, logic [7:0] se);
    step(tag, 0, 0, 0, 0, 1, mi, hr, dy, se);
  endtask

  function automatic logic [7:0] rbcd(int unsigned lim);
    int unsigned v;
    v = $urandom % lim;
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk8("R1", "flag", {7'd0, alarm_flag}, 8'd0);
    chk8("R1", "irq", {7'd0, alarm_irq}, 8'd0);
    chk8("R1", "rdata", bus_rdata, 8'd0);
    @(negedge clk);
    rst = 1'b0;
    rd("R1", 0); rd("R1", 1); rd("R1", 2);

    // R2: write and read back each slot, slot 3 reads 0
    wr("R2", 0, 8'h30); wr("R2", 1, 8'h12); wr("R2", 2, 8'h05);
    rd("R2", 0); rd("R2", 1); rd("R2", 2); rd("R2", 3);
    // R3: pad bits of day slot read zero
    wr("R3", 2, 8'h7D); rd("R3", 2);
    wr("R3", 2, 8'h05);

    // R4: full match required
    ev("R4", 8'h30, 8'h12, 8'h06, 8'h10);
    ev("R4", 8'h31, 8'h12, 8'h05, 8'h10);
    ev("R4", 8'h30, 8'h12, 8'h05, 8'h10);
    // R9: sticky, slot 3 access leaves it, alarm slot read clears it
    idle("R9"); idle("R9");
    rd("R9", 3); wr("R9", 3, 8'hFF);
    rd("R9", 0);
    idle("R9");
    // R8: match without strobe
    step("R8", 0, 0, 0, 0, 0, 8'h30, 8'h12, 8'h05, 8'h59);

    // R5: day masked
    wr("R5", 2, 8'h83);
    ev("R5", 8'h30, 8'h13, 8'h06, 8'h00);
    ev("R5", 8'h30, 8'h12, 8'h06, 8'h00);
    wr("R5", 0, 8'h30);
    // R6: day and hour masked
    wr("R6", 1, 8'h92);
    ev("R6", 8'h31, 8'h07, 8'h01, 8'h00);
    ev("R6", 8'h30, 8'h07, 8'h01, 8'h00);
    rd("R6", 1);
    // R7: all masked, fires only at second 59
    wr("R7", 0, 8'hB0);
    ev("R7", 8'h17, 8'h03, 8'h02, 8'h58);
    ev("R7", 8'h17, 8'h03, 8'h02, 8'h59);
    wr("R7", 3, 8'h00);
    rd("R7", 2);
    // R10: hit collides with alarm write; old minute value still masked
    step("R10", 1, 1, 0, 8'h45, 1, 8'h22, 8'h01, 8'h03, 8'h59);
    rd("R10", 0);
    ev("R10", 8'h22, 8'h01, 8'h03, 8'h59);
    // R10: collision with a read
    step("R10", 1, 0, 2, 8'h00, 1, 8'h45, 8'h09, 8'h04, 8'h00);
    rd("R10", 1);

    // random phase: R4 R5 R6 R7 R9 R10
    for (int i = 0; i < 400; i++) begin
      logic s, w, c;
      logic [1:0] a;
      logic [7:0] d, mi, hr, dy, se;
      s = ($urandom % 4) == 0;
      w = $urandom % 2;
      a = 2'($urandom % 4);
      case (a)
        2'd0: d = {1'($urandom % 4 == 0), rbcd(60)[6:0]};
        2'd1: d = {1'($urandom % 3 == 0), rbcd(24)[6:0]};
        default: d = 8'($urandom);
      endcase
      c  = $urandom % 2;
      mi = ($urandom % 2) ? {1'b0, m_min[6:0]} : rbcd(60);
      hr = ($urandom % 2) ? {1'b0, m_hour[6:0]} : rbcd(24);
      dy = ($urandom % 2) ? {5'd0, m_day[2:0]} : 8'(1 + $urandom % 7);
      se = ($urandom % 2) ? 8'h59 : rbcd(60);
      step("R4-random", s, w, a, d, c, mi, hr, dy, se);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule